// File: doc/BRIEF.md
# Privileged Translation-Base Register Access Gate

This block owns one 128-bit translation-base control register and judges every system-register access aimed at it. Each request names the privilege level of the requester (0 to 3), whether it reads or writes, whether it is a 64-bit or a 128-bit access, and the write data. From the request and a handful of configuration inputs, the block picks exactly one outcome in the same cycle. The access can complete on the register, be redirected to a memory slot, trap to level 2 or to level 3 with a syndrome code, or be declared undefined.

The configuration inputs are three nested-virtualization control bits, a flag telling whether level 3 exists, a wide-access enable owned by level 3, and a priority flag that chooses undefined over a level-3 trap. They also include a secondary undefined condition and a flag saying whether the wide-register feature is built in. The surrounding core acts on the outcome. The memory transfer, exception entry and table walks are done elsewhere.

The request side is a valid/ready channel. `req_ready` is held high, so the block never applies back-pressure, and every cycle with `req_valid` high is one accepted request. The outcome, syndrome, slot offset and read data are combinational from that request and are valid only in that cycle.

Top module: `sysreg_gate`

## Requirements
- R1: A valid request from level 0 has outcome undefined (`outcome` = 5'b00001), whatever its width and direction.
- R2: At level 1, when control bits 2 and 0 are both 1, the outcome is redirect (`outcome` = 5'b01000) and `mem_slot` = 12'h020. In every other case `mem_slot` is zero.
- R3: At level 1, when control bit 0 is 1 and bit 2 is 0, the outcome is trap to level 2 (`outcome` = 5'b00100). The syndrome is 8'h18 for a 64-bit access and 8'h14 for a 128-bit access.
- R4: At level 1 with control bit 0 equal to 0, the outcome is undefined.
- R5: A 64-bit read that completes returns bits [63:0] in `rdata[63:0]`, with `rdata[127:64]` zero. A 64-bit write that completes changes bits [63:0] only and keeps bits [127:64].
- R6: At level 2, a 64-bit access completes (`outcome` = 5'b10000). A 128-bit access also completes when level 3 is absent or the wide-access enable is 1.
- R7: At level 2, a 128-bit access with level 3 present and the wide-access enable at 0 is undefined when the priority flag is 1 or the secondary undefined input is 1. Otherwise it traps to level 3 (`outcome` = 5'b00010) with syndrome 8'h14.
- R8: At level 3, accesses of both widths complete.
- R9: A 128-bit request while the wide-register feature flag is 0 is undefined at every level.
- R10: A valid request sets exactly one outcome bit. An idle cycle sets none and does not change the register. The syndrome is zero unless the outcome is a trap.
- R11: The register takes write data on the clock edge after a write whose outcome is complete. Reset clears it to zero.
- R12: `rdata` is zero unless the outcome is complete and the request is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_level | input | 2 | Privilege level of requester |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 128-bit access, 0 = 64-bit |
| req_wdata | input | 128 | Write data |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| top_level_present | input | 1 | Level 3 exists |
| wide_enable | input | 1 | Wide-access enable owned by level 3 |
| undef_first | input | 1 | Undefined takes priority over a level-3 trap |
| alt_undef | input | 1 | Secondary undefined condition |
| wide_feature | input | 1 | Wide-register feature built in |
| outcome | output | 5 | One-hot {complete, redirect, trap2, trap3, undefined} |
| syndrome | output | 8 | Trap syndrome code |
| mem_slot | output | 12 | Redirect slot offset |
| rdata | output | 128 | Read data |

## Verification
On every cycle, the assertions check the one-hot outcome, level-0 and level-3 decisions, zero read data on non-completing outcomes, a zero syndrome off traps, and that a narrow or absent write leaves the guarded register bits unchanged. The values themselves can only be shown by the bench scenarios. These include the exact syndrome codes per width, the ordering of the priority flag and secondary condition in the level-2 gate, and the redirect offset. The bench's write-then-read sequences also show what a narrow write merges into the register.

// File: rtl/sysreg_gate_pkg.sv
package sysreg_gate_pkg;
  localparam int REG_W  = 128;
  localparam int HALF_W = REG_W / 2;
  localparam int SYN_W  = 8;
  localparam int SLOT_W = 12;
  localparam int OUT_W  = 5;

  localparam logic [OUT_W-1:0] OC_DONE  = 5'b10000;
  localparam logic [OUT_W-1:0] OC_REDIR = 5'b01000;
  localparam logic [OUT_W-1:0] OC_TRAP2 = 5'b00100;
  localparam logic [OUT_W-1:0] OC_TRAP3 = 5'b00010;
  localparam logic [OUT_W-1:0] OC_UNDEF = 5'b00001;

  localparam logic [SYN_W-1:0] SYN_NARROW = 8'h18;
  localparam logic [SYN_W-1:0] SYN_WIDE   = 8'h14;
  localparam logic [SLOT_W-1:0] SLOT_OFF  = 12'h020;
endpackage

// File: rtl/access_decider.sv
module access_decider
  import sysreg_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [1:0]       level,
  input  logic             wide,
  input  logic [2:0]       nv_ctl,
  input  logic             top_present,
  input  logic             wide_en,
  input  logic             undef_first,
  input  logic             alt_undef,
  input  logic             wide_feature,
  output logic [OUT_W-1:0] oc,
  output logic [SYN_W-1:0] syn
);
  logic wide_gated;
  assign wide_gated = wide && top_present && !wide_en;

  always_comb begin
    oc  = '0;
    syn = '0;
    if (valid) begin
      if (wide && !wide_feature) begin
        oc = OC_UNDEF;
      end else begin
        unique case (level)
          2'd0: oc = OC_UNDEF;
          2'd1: begin
            if (nv_ctl[2] && nv_ctl[0]) begin
              oc = OC_REDIR;
            end else if (nv_ctl[0]) begin
              oc  = OC_TRAP2;
              syn = wide ? SYN_WIDE : SYN_NARROW;
            end else begin
              oc = OC_UNDEF;
            end
          end
          2'd2: begin
            if (wide_gated) begin
              if (undef_first || alt_undef) begin
                oc = OC_UNDEF;
              end else begin
                oc  = OC_TRAP3;
                syn = SYN_WIDE;
              end
            end else begin
              oc = OC_DONE;
            end
          end
          default: oc = OC_DONE;
        endcase
      end
    end
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones(oc) == 1);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> oc == '0);
  assert_syn_only_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oc != OC_TRAP2 && oc != OC_TRAP3) |-> syn == '0);
  assert_level0_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && level == 2'd0) |-> oc == OC_UNDEF);
  assert_level3_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && level == 2'd3 && (wide_feature || !wide)) |-> oc == OC_DONE);
  assert_nofeat_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wide && !wide_feature) |-> oc == OC_UNDEF);
endmodule

// File: rtl/base_reg_store.sv
module base_reg_store
  import sysreg_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             wide,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hit;
    assign hit = wr_en && ((h == 0) || wide);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[h*HALF_W +: HALF_W] <= '0;
      else if (hit) q[h*HALF_W +: HALF_W] <= wdata[h*HALF_W +: HALF_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[HALF_W-1:0] = q[HALF_W-1:0];
      if (wide) rdata[REG_W-1:HALF_W] = q[REG_W-1:HALF_W];
    end
  end

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wide) |=> $stable(q[REG_W-1:HALF_W]));
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  assert_quiet_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: rtl/sysreg_gate.sv
module sysreg_gate
  import sysreg_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_level,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [2:0]        nv_ctl,
  input  logic              top_level_present,
  input  logic              wide_enable,
  input  logic              undef_first,
  input  logic              alt_undef,
  input  logic              wide_feature,
  output logic [OUT_W-1:0]  outcome,
  output logic [SYN_W-1:0]  syndrome,
  output logic [SLOT_W-1:0] mem_slot,
  output logic [REG_W-1:0]  rdata
);
  logic done;

  assign req_ready = 1'b1;

  access_decider u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (req_valid),
    .level        (req_level),
    .wide         (req_wide),
    .nv_ctl       (nv_ctl),
    .top_present  (top_level_present),
    .wide_en      (wide_enable),
    .undef_first  (undef_first),
    .alt_undef    (alt_undef),
    .wide_feature (wide_feature),
    .oc           (outcome),
    .syn          (syndrome)
  );

  assign done     = outcome == OC_DONE;
  assign mem_slot = (outcome == OC_REDIR) ? SLOT_OFF : '0;

  base_reg_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (done && req_write),
    .rd_en (done && !req_write),
    .wide  (req_wide),
    .wdata (req_wdata),
    .rdata (rdata)
  );

  assert_rdata_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome != OC_DONE) |-> rdata == '0);
  assert_slot_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome != OC_REDIR) |-> mem_slot == '0);
endmodule

// File: tb/tb_sysreg_gate.sv
`timescale 1ns/1ps
module tb_sysreg_gate;
  import sysreg_gate_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_level = '0;
  logic req_write = 1'b0;
  logic req_wide = 1'b0;
  logic [127:0] req_wdata = '0;
  logic [2:0] nv_ctl = '0;
  logic top_level_present = 1'b0;
  logic wide_enable = 1'b0;
  logic undef_first = 1'b0;
  logic alt_undef = 1'b0;
  logic wide_feature = 1'b1;
  logic [4:0] outcome;
  logic [7:0] syndrome;
  logic [11:0] mem_slot;
  logic [127:0] rdata;

  int vectors = 0;
  int errs = 0;
  logic [127:0] model = '0;

  always #2 clk = ~clk;

  sysreg_gate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata), .nv_ctl(nv_ctl), .top_level_present(top_level_present),
    .wide_enable(wide_enable), .undef_first(undef_first), .alt_undef(alt_undef),
    .wide_feature(wide_feature), .outcome(outcome), .syndrome(syndrome),
    .mem_slot(mem_slot), .rdata(rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] lvl, input logic wr, input logic wd,
                        input logic [127:0] data, input logic [4:0] exp_o,
                        input logic [7:0] exp_s, input string tag);
    logic [127:0] er;
    @(negedge clk);
    req_valid = 1'b1; req_level = lvl; req_write = wr; req_wide = wd; req_wdata = data;
    #1;
    er = '0;
    if (exp_o == OC_DONE && !wr) er = wd ? model : {64'b0, model[63:0]};
    check(tag, "outcome", 128'(outcome), 128'(exp_o));
    check(tag, "syndrome", 128'(syndrome), 128'(exp_s));
    check(tag, "mem_slot", 128'(mem_slot), (exp_o == OC_REDIR) ? 128'h20 : 128'h0);
    check(tag, "rdata", rdata, er);
    check(tag, "ready", 128'(req_ready), 128'h1);
    @(posedge clk);
    if (exp_o == OC_DONE && wr) begin
      if (wd) model = data;
      else    model[63:0] = data[63:0];
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R10", "idle outcome", 128'(outcome), 128'h0);
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R11 reset value");
  endtask

  task automatic t_level0;
    do_req(2'd0, 1'b0, 1'b0, '0, OC_UNDEF, 8'h00, "R1 read64");
    do_req(2'd0, 1'b1, 1'b1, {128{1'b1}}, OC_UNDEF, 8'h00, "R1 write128");
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R1 no write");
  endtask

  task automatic t_level1;
    nv_ctl = 3'b101;
    do_req(2'd1, 1'b0, 1'b0, '0, OC_REDIR, 8'h00, "R2 redirect64");
    nv_ctl = 3'b111;
    do_req(2'd1, 1'b1, 1'b1, 128'h5, OC_REDIR, 8'h00, "R2 redirect128");
    nv_ctl = 3'b011;
    do_req(2'd1, 1'b0, 1'b0, '0, OC_TRAP2, 8'h18, "R3 trap64");
    nv_ctl = 3'b001;
    do_req(2'd1, 1'b1, 1'b1, 128'h7, OC_TRAP2, 8'h14, "R3 trap128");
    nv_ctl = 3'b110;
    do_req(2'd1, 1'b0, 1'b1, '0, OC_UNDEF, 8'h00, "R4 undef");
    nv_ctl = 3'b000;
    do_req(2'd1, 1'b1, 1'b0, 128'h9, OC_UNDEF, 8'h00, "R4 undef none");
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R12 no write from l1");
  endtask

  task automatic t_narrow;
    do_req(2'd3, 1'b1, 1'b1, 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444, OC_DONE, 8'h00, "R11 wide write");
    do_req(2'd3, 1'b1, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_5555_6666_7777_8888, OC_DONE, 8'h00, "R5 narrow write");
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R5 upper kept");
    do_req(2'd2, 1'b0, 1'b0, '0, OC_DONE, 8'h00, "R5 narrow read");
  endtask

  task automatic t_level2;
    top_level_present = 1'b0; wide_enable = 1'b0;
    do_req(2'd2, 1'b1, 1'b1, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677, OC_DONE, 8'h00, "R6 no l3");
    top_level_present = 1'b1; wide_enable = 1'b1;
    do_req(2'd2, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R6 enabled");
    wide_enable = 1'b0;
    do_req(2'd2, 1'b0, 1'b0, '0, OC_DONE, 8'h00, "R6 narrow gated");
    undef_first = 1'b1;
    do_req(2'd2, 1'b1, 1'b1, '0, OC_UNDEF, 8'h00, "R7 priority");
    undef_first = 1'b0; alt_undef = 1'b1;
    do_req(2'd2, 1'b0, 1'b1, '0, OC_UNDEF, 8'h00, "R7 secondary");
    alt_undef = 1'b0;
    do_req(2'd2, 1'b1, 1'b1, '1, OC_TRAP3, 8'h14, "R7 trap3");
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R8 read after trap");
    top_level_present = 1'b0;
  endtask

  task automatic t_nofeature;
    wide_feature = 1'b0;
    do_req(2'd3, 1'b1, 1'b1, '1, OC_UNDEF, 8'h00, "R9 l3");
    nv_ctl = 3'b101;
    do_req(2'd1, 1'b0, 1'b1, '0, OC_UNDEF, 8'h00, "R9 l1");
    do_req(2'd3, 1'b0, 1'b0, '0, OC_DONE, 8'h00, "R9 narrow ok");
    wide_feature = 1'b1; nv_ctl = 3'b000;
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_level = 2'd3; req_write = 1'b1; req_wide = 1'b1; req_wdata = '1;
    #1;
    check("R10", "idle outcome", 128'(outcome), 128'h0);
    check("R12", "idle rdata", rdata, 128'h0);
    @(posedge clk);
    do_req(2'd3, 1'b0, 1'b1, '0, OC_DONE, 8'h00, "R10 idle no write");
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    t_reset();
    t_level0();
    t_level1();
    t_narrow();
    t_level2();
    t_nofeature();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule